// File: doc/BRIEF.md
# Interrupt Coalescing Timer Unit

This block sits between the per-packet completion strobes of a network controller and its interrupt logic. It merges completion events into fewer interrupt requests, separately for the transmit and the receive direction. Each direction keeps a pending-event count and raises its request once the count reaches a 3-bit threshold. A 4-bit timeout also bounds how long a lone event can wait. The timeout is counted in whole "time cycles".

The length of a time cycle depends on a shared link-speed input and on a per-direction cycle-length select. A prescaler counts pulses of a reference tick strobe. With the default `BASE_TICKS` of 512 and a tick every 10 ns, the cycle lengths are as follows:
- 5.12 us at 100 Mbps with short cycles.
- 51.2 us at 10 Mbps with short cycles.
- 81.92 us at 100 Mbps with long cycles.
- 819.2 us at 10 Mbps with long cycles.

Threshold 1 with timeout 0 gives one request per event. Each request is a single-clock pulse.

Top module: `irq_coalesce_timer`

## Requirements
- R1: After reset both request outputs are low, and no request appears without an event.
- R2: With threshold N of 2 to 7, the request pulses in the cycle after the clock edge that samples the N-th pending event. The pulse is exactly one clock wide, and no request is raised for fewer events.
- R3: With threshold 0 or 1, every sampled event gives a request in the next cycle.
- R4: With timeout T from 1 to 15 and at least one event pending, the request pulses T*P reference ticks after the first pending event, with P the cycle length in ticks. With the tick asserted every clock, this is the cycle after the edge lying T*P clocks past the edge that sampled the event.
- R5: The cycle length P is computed from `spd_10_i` and the direction's long-cycle select (`*_long_i`):
  - P = BASE_TICKS when `spd_10_i`=0 and the select is 0.
  - P = 10*BASE_TICKS when `spd_10_i`=1 and the select is 0.
  - P = 16*BASE_TICKS when `spd_10_i`=0 and the select is 1.
  - P = 160*BASE_TICKS when `spd_10_i`=1 and the select is 1.
- R6: A timeout of 0 disables the timer. Events below the threshold then stay pending with no request, however long they wait.
- R7: A request clears the pending count and the elapsed time. Later events are counted from zero.
- R8: An event sampled on the same edge as the timeout expiry yields one single request. That event is absorbed into this request and is not carried over as pending.
- R9: Transmit and receive are independent: events, thresholds, timeouts and cycle selects of one direction never cause or delay a request on the other.
- R10: The timer advances only on clocks with `ref_tick_i` high. While the tick is held low, no timeout request occurs.
- R11: After a request, the next timeout is measured from the next first pending event, not from the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | Reference tick strobe feeding the cycle prescalers |
| spd_10_i | input | 1 | 1 = 10 Mbps link, 0 = 100 Mbps link |
| tx_evt_i | input | 1 | Transmit completion event, one per clock at most |
| tx_thr_i | input | 3 | Transmit event-count threshold |
| tx_tmo_i | input | 4 | Transmit timeout in time cycles, 0 = off |
| tx_long_i | input | 1 | Transmit long-cycle select |
| rx_evt_i | input | 1 | Receive completion event, one per clock at most |
| rx_thr_i | input | 3 | Receive event-count threshold |
| rx_tmo_i | input | 4 | Receive timeout in time cycles, 0 = off |
| rx_long_i | input | 1 | Receive long-cycle select |
| tx_irq_o | output | 1 | Transmit interrupt request pulse |
| rx_irq_o | output | 1 | Receive interrupt request pulse |

## Verification
The count path and the timer path can both fire on the same clock edge. The bench provokes this by placing the first event and then timing a second event to land exactly on the edge where one time cycle expires. It does this once with the threshold also reached and once with it not reached. It then judges that exactly one pulse appears. After the threshold is raised and the timer disabled, it checks that a fresh run of events needs the full threshold again, which shows that the coinciding event was absorbed rather than left pending.

// File: rtl/coal_pkg.sv
package coal_pkg;
    parameter int THR_W = 3;
    parameter int TMO_W = 4;
    parameter int N_DIR = 2;

    // Multiplier of the base cycle length for a speed / cycle-length choice.
    function automatic int cyc_mult(input logic spd_10, input logic long_c);
        int m;
        m = 1;
        if (spd_10) m = m * 10;
        if (long_c) m = m * 16;
        return m;
    endfunction

    typedef struct packed {
        logic [THR_W-1:0] cnt;
        logic [TMO_W-1:0] cyc;
        logic             irq;
    } dir_state_t;
endpackage

// File: rtl/coal_cycle_gen.sv
module coal_cycle_gen #(
    parameter int BASE_TICKS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic ref_tick_i,
    input  logic spd_10_i,
    input  logic long_i,
    output logic cyc_tick_o
);
    import coal_pkg::*;

    localparam int MAX_P = BASE_TICKS * 160;
    localparam int PW    = $clog2(MAX_P + 1);

    logic [PW-1:0] pcnt_d, pcnt_q, period;

    always_comb begin
        period     = PW'(BASE_TICKS * cyc_mult(spd_10_i, long_i));
        cyc_tick_o = run_i && ref_tick_i && (pcnt_q == period - 1'b1);
        pcnt_d     = pcnt_q;
        if (!run_i)          pcnt_d = '0;
        else if (ref_tick_i) pcnt_d = cyc_tick_o ? '0 : pcnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q < period); // R5
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !ref_tick_i) |=> (pcnt_q == $past(pcnt_q))); // R10
endmodule

// File: rtl/coal_dir.sv
module coal_dir #(
    parameter int BASE_TICKS = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ref_tick_i,
    input  logic                       spd_10_i,
    input  logic                       evt_i,
    input  logic [coal_pkg::THR_W-1:0] thr_i,
    input  logic [coal_pkg::TMO_W-1:0] tmo_i,
    input  logic                       long_i,
    output logic                       irq_o
);
    import coal_pkg::*;

    dir_state_t       st_d, st_q;
    logic [THR_W-1:0] thr_eff;
    logic             pending, run, cyc_tick, thr_hit, tmo_hit;

    always_comb begin
        thr_eff = (thr_i == '0) ? THR_W'(1) : thr_i;
        pending = (st_q.cnt != '0);
        run     = pending && (tmo_i != '0);
    end

    coal_cycle_gen #(.BASE_TICKS(BASE_TICKS)) u_cyc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .ref_tick_i (ref_tick_i),
        .spd_10_i   (spd_10_i),
        .long_i     (long_i),
        .cyc_tick_o (cyc_tick)
    );

    always_comb begin
        thr_hit = evt_i && (({1'b0, st_q.cnt} + 1'b1) >= {1'b0, thr_eff});
        tmo_hit = run && cyc_tick && (({1'b0, st_q.cyc} + 1'b1) == {1'b0, tmo_i});
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (thr_hit || tmo_hit) begin
            st_d.cnt = '0;
            st_d.cyc = '0;
            st_d.irq = 1'b1;
        end else begin
            if (evt_i)    st_d.cnt = st_q.cnt + 1'b1;
            if (!pending) st_d.cyc = '0;
            else if (cyc_tick) st_d.cyc = st_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.cnt == '0 && st_q.cyc == '0)); // R7
    AST_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && thr_i <= THR_W'(1)) |=> st_q.irq); // R3
    AST_NO_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !$past(evt_i)) |-> ($past(tmo_i) != '0)); // R6
    AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && tmo_i != '0) |-> (st_q.cyc < tmo_i)); // R4
endmodule

// File: rtl/irq_coalesce_timer.sv
module irq_coalesce_timer #(
    parameter int BASE_TICKS = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick_i,
    input  logic       spd_10_i,
    input  logic       tx_evt_i,
    input  logic [2:0] tx_thr_i,
    input  logic [3:0] tx_tmo_i,
    input  logic       tx_long_i,
    input  logic       rx_evt_i,
    input  logic [2:0] rx_thr_i,
    input  logic [3:0] rx_tmo_i,
    input  logic       rx_long_i,
    output logic       tx_irq_o,
    output logic       rx_irq_o
);
    import coal_pkg::*;

    logic [N_DIR-1:0]            evt, lng, irq;
    logic [N_DIR-1:0][THR_W-1:0] thr;
    logic [N_DIR-1:0][TMO_W-1:0] tmo;

    // Index 0 = transmit, index 1 = receive.
    assign evt = {rx_evt_i, tx_evt_i};
    assign lng = {rx_long_i, tx_long_i};
    assign thr = {rx_thr_i, tx_thr_i};
    assign tmo = {rx_tmo_i, tx_tmo_i};

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        coal_dir #(.BASE_TICKS(BASE_TICKS)) u_dir (
            .clk        (clk),
            .rst_n      (rst_n),
            .ref_tick_i (ref_tick_i),
            .spd_10_i   (spd_10_i),
            .evt_i      (evt[d]),
            .thr_i      (thr[d]),
            .tmo_i      (tmo[d]),
            .long_i     (lng[d]),
            .irq_o      (irq[d])
        );
    end

    assign tx_irq_o = irq[0];
    assign rx_irq_o = irq[1];
endmodule

// File: tb/irq_coalesce_timer_tb_top.sv
module irq_coalesce_timer_tb_top;
    localparam int BASE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b1, spd_10 = 1'b0;
    logic tx_evt = 1'b0, rx_evt = 1'b0, tx_long = 1'b0, rx_long = 1'b0;
    logic [2:0] tx_thr = 3'd1, rx_thr = 3'd1;
    logic [3:0] tx_tmo = 4'd0, rx_tmo = 4'd0;
    logic tx_irq, rx_irq;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_coalesce_timer #(.BASE_TICKS(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .spd_10_i(spd_10),
        .tx_evt_i(tx_evt), .tx_thr_i(tx_thr), .tx_tmo_i(tx_tmo), .tx_long_i(tx_long),
        .rx_evt_i(rx_evt), .rx_thr_i(rx_thr), .rx_tmo_i(rx_tmo), .rx_long_i(rx_long),
        .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        tx_evt = 0; rx_evt = 0; ref_tick = 1; spd_10 = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic pulse_rx();
        rx_evt = 1; @(negedge clk); rx_evt = 0;
    endtask

    task automatic pulse_tx();
        tx_evt = 1; @(negedge clk); tx_evt = 0;
    endtask

    // Clocks from the sampling edge of the event until rx_irq is seen.
    task automatic wait_rx(input int lim, output int n);
        n = 0;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (rx_irq) begin n = i; break; end
        end
    endtask

    task automatic t_reset();
        rst_n = 0; @(negedge clk);
        chk("R1 tx_irq in reset", tx_irq, 0);
        chk("R1 rx_irq in reset", rx_irq, 0);
        do_reset();
        repeat (20) @(negedge clk);
        chk("R1 no request without events", tx_irq | rx_irq, 0);
    endtask

    task automatic t_immediate();
        do_reset();
        rx_thr = 1; rx_tmo = 0;
        pulse_rx(); chk("R3 thr=1 immediate", rx_irq, 1);
        @(negedge clk); chk("R2 pulse one clock", rx_irq, 0);
        rx_thr = 0;
        pulse_rx(); chk("R3 thr=0 immediate", rx_irq, 1);
        chk("R9 tx untouched by rx", tx_irq, 0);
        rx_evt = 1; @(negedge clk); chk("R3 back-to-back 1", rx_irq, 1);
        @(negedge clk); rx_evt = 0; chk("R3 back-to-back 2", rx_irq, 1);
    endtask

    task automatic t_threshold();
        do_reset();
        rx_thr = 3; rx_tmo = 0;
        pulse_rx(); chk("R2 first of 3", rx_irq, 0);
        pulse_rx(); chk("R2 second of 3", rx_irq, 0);
        pulse_rx(); chk("R2 third of 3", rx_irq, 1);
        @(negedge clk); chk("R2 width", rx_irq, 0);
        pulse_rx(); pulse_rx();
        chk("R7 count restarted", rx_irq, 0);
        begin
            int seen = 0;
            repeat (300) begin @(negedge clk); if (rx_irq) seen++; end
            chk("R6 timeout 0 never fires", seen, 0);
        end
        pulse_rx(); chk("R7 fires on third fresh event", rx_irq, 1);
    endtask

    task automatic t_timeout();
        int n;
        for (int k = 0; k < 4; k++) begin
            int p;
            do_reset();
            spd_10 = k[0]; rx_long = k[1]; tx_long = ~k[1];
            rx_thr = 7; rx_tmo = 2;
            p = BASE * (k[0] ? 10 : 1) * (k[1] ? 16 : 1);
            pulse_rx();
            wait_rx(2 * p + 50, n);
            chk($sformatf("R4 R5 timeout spd10=%0d long=%0d", k[0], k[1]), n, 2 * p);
            @(negedge clk); chk("R2 timeout pulse width", rx_irq, 0);
        end
        rx_long = 0; tx_long = 0; spd_10 = 0;
    endtask

    task automatic t_coincide();
        do_reset();
        rx_thr = 2; rx_tmo = 1;
        pulse_rx();
        repeat (3) @(negedge clk);
        chk("R8 no early request", rx_irq, 0);
        pulse_rx(); chk("R8 thr+tmo same edge", rx_irq, 1);
        @(negedge clk); chk("R8 single pulse", rx_irq, 0);
        do_reset();
        rx_thr = 3; rx_tmo = 1;
        pulse_rx();
        repeat (3) @(negedge clk);
        pulse_rx(); chk("R8 tmo with event", rx_irq, 1);
        @(negedge clk); chk("R8 single pulse 2", rx_irq, 0);
        rx_tmo = 0;
        pulse_rx(); pulse_rx();
        chk("R8 event absorbed", rx_irq, 0);
        pulse_rx(); chk("R8 fresh count of three", rx_irq, 1);
    endtask

    task automatic t_refgate();
        int n;
        do_reset();
        rx_thr = 7; rx_tmo = 1;
        ref_tick = 0;
        pulse_rx();
        begin
            int seen = 0;
            repeat (100) begin @(negedge clk); if (rx_irq) seen++; end
            chk("R10 held tick blocks timer", seen, 0);
        end
        ref_tick = 1;
        wait_rx(50, n);
        chk("R10 timer resumes on ticks", n, BASE);
    endtask

    task automatic t_restart();
        int n;
        do_reset();
        rx_thr = 7; rx_tmo = 1;
        pulse_rx(); wait_rx(50, n);
        chk("R4 first timeout", n, BASE);
        repeat (10) @(negedge clk);
        pulse_rx(); wait_rx(50, n);
        chk("R11 timer restarts at new event", n, BASE);
    endtask

    task automatic t_indep();
        do_reset();
        tx_thr = 2; tx_tmo = 0; rx_thr = 1; rx_tmo = 0;
        pulse_tx(); chk("R9 tx below threshold", tx_irq, 0);
        pulse_rx(); chk("R9 rx fires alone", rx_irq, 1);
        chk("R9 tx still quiet", tx_irq, 0);
        pulse_tx(); chk("R9 tx fires on second", tx_irq, 1);
        chk("R9 rx quiet", rx_irq, 0);
    endtask

    initial begin
        t_reset();
        t_immediate();
        t_threshold();
        t_timeout();
        t_coincide();
        t_refgate();
        t_restart();
        t_indep();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule